// File: doc/BRIEF.md
# Linear Image Sensor Readout Sequencer

This block runs a linear photodiode-array sensor that has three connections: a serial-start input, a pixel clock input and one analog output. An external converter samples the analog output in free-running mode. The sequencer does not run the pixel clock on a fixed schedule. It produces one clock pulse for each sample-ready strobe from the converter. On each strobe it raises the clock, writes the held conversion result into pixel memory, and then lowers the clock, always in that order. Because the next pixel is placed on the analog output as soon as the clock rises, it has time to settle while the new conversion runs.

Pixel memory is split into two halves. Every capture start swaps the halves: the new capture fills one half, and the read port shows the other, stable half. A consumer therefore starts capture k+1 and then reads the image from capture k while the sensor is being clocked. After reset the block makes two clearing passes through the array before it accepts any capture. It also records how many cycles each capture took and how many captures have finished.

Top module: `lsr_sequencer`

## Requirements
- R1: While reset is held, `sensor_clk`, `sensor_si`, `adc_run`, `busy`, `capture_done` and `overrun` are 0, and `capture_count` and `capture_cycles` are 0.
- R2: After reset is released, the block makes CLEAR_PASSES (default 2) clearing passes before the first capture. Each pass is one serial-start pulse followed by NPIX+1 plain clock pulses. So 2·(NPIX+2) clock pulses, two of them carrying the serial-start pulse, come before the first capture begins. `adc_run` stays low throughout.
- R3: A capture begins with `sensor_si` and `sensor_clk` rising on the same cycle. `sensor_si` falls one cycle before `sensor_clk` falls. One further clock pulse follows, and `adc_run` rises only after that pulse has ended.
- R4: A strobe on `adc_ready` that arrives while the block is waiting for a sample makes `sensor_clk` high in the very next cycle.
- R5: Every clock pulse is high for exactly HIGH_CYC cycles and low for at least LOW_CYC cycles. For each accepted strobe, the sample is stored after the clock has risen and before it falls.
- R6: Once the NPIX-th strobe has been accepted, `adc_run` goes low in the same cycle that the clock rises. One trailing clock pulse follows. `capture_done` is then raised. A capture contains exactly NPIX+3 clock pulses in total.
- R7: A strobe that arrives during the high or low phase of a pixel pulse raises `overrun` for one cycle. That strobe is otherwise ignored: nothing is stored and no clock pulse is made.
- R8: The k-th accepted sample of a capture is stored at pixel address k. The data of capture k can be read from the cycle after capture k+1 starts. `rd_data` follows `rd_addr` by one cycle.
- R9: A `capture_req` pulse that arrives while a clearing pass or a capture is running is held, and the capture starts once the running operation ends. Several requests made during one capture produce a single extra capture.
- R10: One cycle after `capture_done`, `capture_cycles` holds the number of cycles `busy` was high during that capture, and `capture_count` has increased by one.
- R11: `busy` is high from the cycle after a capture is accepted until `capture_done`. `capture_done` is a one-cycle pulse during which `busy` is already low. `adc_run` is never high while `busy` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| capture_req | input | 1 | One-cycle request to capture a frame |
| adc_ready | input | 1 | One-cycle sample-ready strobe from the converter |
| adc_data | input | DW | Held conversion result |
| adc_run | output | 1 | Enables the converter's free-running sampling |
| sensor_si | output | 1 | Serial-start line to the sensor |
| sensor_clk | output | 1 | Pixel clock to the sensor |
| rd_addr | input | AW | Pixel address for the stable half |
| rd_data | output | DW | Pixel value, one cycle after `rd_addr` |
| busy | output | 1 | A capture is in progress |
| capture_done | output | 1 | One-cycle end-of-capture pulse |
| overrun | output | 1 | A strobe arrived while a pixel pulse was still running |
| capture_cycles | output | CW | Busy length of the last completed capture |
| capture_count | output | NW | Number of completed captures |

## Verification
All pin outputs come from registers. A strobe or request sampled at one edge therefore shows its result after that same edge: the clock rise, the `overrun` flag, the `adc_run` change and `busy` are all checked at the falling edge that follows the sampling edge. The statistics update one edge after `capture_done`, so they are checked one falling edge after the pulse is seen. Memory reads are given an address on one falling edge and compared on the next. Stimulus is driven with nonblocking assignments on the falling edge, so the monitor always sees the values that the design sampled.

// File: rtl/lsr_pkg.sv
// Package: shared state encoding for the sensor readout sequencer.
// Assumes: only the sequencer top and its bench import it.
package lsr_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SI_HI,
        ST_SI_LO,
        ST_CLR_HI,
        ST_CLR_LO,
        ST_PRE_HI,
        ST_PRE_LO,
        ST_WAIT,
        ST_PIX_HI,
        ST_PIX_LO,
        ST_TAIL_HI,
        ST_TAIL_LO
    } seq_state_t;

    // True for every state in which the pixel clock is driven high.
    function automatic logic clk_high(seq_state_t s);
        return (s == ST_SI_HI) || (s == ST_CLR_HI) || (s == ST_PRE_HI) ||
               (s == ST_PIX_HI) || (s == ST_TAIL_HI);
    endfunction

endpackage

// File: rtl/lsr_req_hold.sv
// Module: holds a capture request until the sequencer can take it.
// Assumes: req_i is a pulse; take_i is high only in a cycle in which pend_o is high.
module lsr_req_hold (
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    input  logic take_i,
    output logic pend_o
);

    logic pend_q;

    assign pend_o = pend_q | req_i;

    // Remember a request until it is accepted; later requests merge into it.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= 1'b0;
        else        pend_q <= pend_o & ~take_i;
    end

    a_r9_take_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
        take_i |-> pend_o);

endmodule

// File: rtl/lsr_pingpong_mem.sv
// Module: two-half pixel store with one write port and one registered read port.
// Assumes: addresses are below NPIX; the caller chooses which half each port uses.
module lsr_pingpong_mem #(
    parameter int NPIX = 1280,
    parameter int DW   = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    we,
    input  logic                    wr_bank,
    input  logic [$clog2(NPIX)-1:0] wr_addr,
    input  logic [DW-1:0]           wr_data,
    input  logic                    rd_bank,
    input  logic [$clog2(NPIX)-1:0] rd_addr,
    output logic [DW-1:0]           rd_data
);

    localparam int DEPTH = 2 * NPIX;
    localparam int IW    = $clog2(DEPTH);

    logic [DW-1:0] mem [DEPTH];
    logic [IW-1:0] wr_idx;
    logic [IW-1:0] rd_idx;

    // Place the upper half directly after the lower half.
    assign wr_idx = wr_bank ? IW'(NPIX) + IW'(wr_addr) : IW'(wr_addr);
    assign rd_idx = rd_bank ? IW'(NPIX) + IW'(rd_addr) : IW'(rd_addr);

    // Store one sample.
    always_ff @(posedge clk) begin
        if (we) mem[wr_idx] <= wr_data;
    end

    // Registered read from the half the consumer sees.
    always_ff @(posedge clk) begin
        if (!rst_n) rd_data <= '0;
        else        rd_data <= mem[rd_idx];
    end

endmodule

// File: rtl/lsr_capture_stats.sv
// Module: records the busy length of each capture and counts completed captures.
// Assumes: done_i pulses for one cycle while busy_i is already low.
module lsr_capture_stats #(
    parameter int CW = 32,
    parameter int NW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          busy_i,
    input  logic          done_i,
    output logic [CW-1:0] cycles_o,
    output logic [NW-1:0] count_o
);

    logic [CW-1:0] run_q;

    // Count busy cycles of the current capture; restart after each finish.
    always_ff @(posedge clk) begin
        if (!rst_n)      run_q <= '0;
        else if (done_i) run_q <= '0;
        else if (busy_i) run_q <= run_q + 1'b1;
    end

    // Latch the finished length and step the capture count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cycles_o <= '0;
            count_o  <= '0;
        end else if (done_i) begin
            cycles_o <= run_q;
            count_o  <= count_o + 1'b1;
        end
    end

    a_r10_count_steps: assert property (@(posedge clk) disable iff (!rst_n)
        done_i |=> count_o == $past(count_o) + 1'b1);

endmodule

// File: rtl/lsr_sequencer.sv
// Module: sequences the serial-start and pixel-clock lines of a linear sensor
// and steps them with the converter's sample-ready strobe. Each strobe raises
// the clock, stores the held sample and then lowers the clock. Captures fill
// alternating halves of pixel memory.
// Assumes: HIGH_CYC >= 2 and LOW_CYC >= 1; adc_ready is a one-cycle pulse.
module lsr_sequencer #(
    parameter int NPIX         = 1280,
    parameter int DW           = 8,
    parameter int HIGH_CYC     = 5,
    parameter int LOW_CYC      = 5,
    parameter int CLEAR_PASSES = 2,
    parameter int CW           = 32,
    parameter int NW           = 16,
    localparam int AW          = $clog2(NPIX)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          capture_req,
    input  logic          adc_ready,
    input  logic [DW-1:0] adc_data,
    output logic          adc_run,
    output logic          sensor_si,
    output logic          sensor_clk,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    output logic          busy,
    output logic          capture_done,
    output logic          overrun,
    output logic [CW-1:0] capture_cycles,
    output logic [NW-1:0] capture_count
);
    import lsr_pkg::*;

    localparam int TMAX = (HIGH_CYC > LOW_CYC) ? HIGH_CYC : LOW_CYC;
    localparam int TW   = $clog2(TMAX + 1);
    localparam int PW   = $clog2(NPIX + 2);
    localparam int IPW  = $clog2(CLEAR_PASSES + 1);
    localparam logic [TW-1:0] HI_LAST  = TW'(HIGH_CYC - 1);
    localparam logic [TW-1:0] LO_LAST  = TW'(LOW_CYC - 1);
    localparam logic [PW-1:0] PIX_LAST = PW'(NPIX - 1);
    localparam logic [PW-1:0] CLR_LAST = PW'(NPIX);

    seq_state_t      state_q, state_n;
    logic [TW-1:0]   tcnt_q, tcnt_n;
    logic [PW-1:0]   pcnt_q, pcnt_n;
    logic [IPW-1:0]  init_q, init_n;
    logic            clr_q, clr_n;
    logic            bank_q;
    logic [DW-1:0]   sample_q;
    logic            pending, start_cap, cap_end, hi_end, lo_end, store_we;

    lsr_req_hold u_req (
        .clk    (clk),
        .rst_n  (rst_n),
        .req_i  (capture_req),
        .take_i (start_cap),
        .pend_o (pending)
    );

    assign hi_end   = (tcnt_q == HI_LAST);
    assign lo_end   = (tcnt_q == LO_LAST);
    assign store_we = (state_q == ST_PIX_HI) && (tcnt_q == '0);

    // Next-state logic for the clear, capture and per-pixel pulse sequences.
    always_comb begin
        state_n   = state_q;
        pcnt_n    = pcnt_q;
        init_n    = init_q;
        clr_n     = clr_q;
        start_cap = 1'b0;
        cap_end   = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (init_q != '0) begin
                    state_n = ST_SI_HI;
                    clr_n   = 1'b1;
                end else if (pending) begin
                    state_n   = ST_SI_HI;
                    clr_n     = 1'b0;
                    start_cap = 1'b1;
                end
            end
            ST_SI_HI:  if (hi_end) state_n = ST_SI_LO;
            ST_SI_LO: begin
                if (lo_end) begin
                    pcnt_n  = '0;
                    state_n = clr_q ? ST_CLR_HI : ST_PRE_HI;
                end
            end
            ST_CLR_HI: if (hi_end) state_n = ST_CLR_LO;
            ST_CLR_LO: begin
                if (lo_end) begin
                    if (pcnt_q == CLR_LAST) begin
                        state_n = ST_IDLE;
                        init_n  = init_q - 1'b1;
                    end else begin
                        pcnt_n  = pcnt_q + 1'b1;
                        state_n = ST_CLR_HI;
                    end
                end
            end
            ST_PRE_HI: if (hi_end) state_n = ST_PRE_LO;
            ST_PRE_LO: begin
                if (lo_end) begin
                    pcnt_n  = '0;
                    state_n = ST_WAIT;
                end
            end
            ST_WAIT:   if (adc_ready) state_n = ST_PIX_HI;
            ST_PIX_HI: if (hi_end) state_n = ST_PIX_LO;
            ST_PIX_LO: begin
                if (lo_end) begin
                    if (pcnt_q == PIX_LAST) begin
                        state_n = ST_TAIL_HI;
                    end else begin
                        pcnt_n  = pcnt_q + 1'b1;
                        state_n = ST_WAIT;
                    end
                end
            end
            ST_TAIL_HI: if (hi_end) state_n = ST_TAIL_LO;
            ST_TAIL_LO: begin
                if (lo_end) begin
                    state_n = ST_IDLE;
                    cap_end = 1'b1;
                end
            end
            default: state_n = ST_IDLE;
        endcase
        tcnt_n = (state_n != state_q) ? '0 : tcnt_q + 1'b1;
    end

    // Sequencer state, phase timer and pixel counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            tcnt_q  <= '0;
            pcnt_q  <= '0;
            init_q  <= IPW'(CLEAR_PASSES);
            clr_q   <= 1'b0;
        end else begin
            state_q <= state_n;
            tcnt_q  <= tcnt_n;
            pcnt_q  <= pcnt_n;
            init_q  <= init_n;
            clr_q   <= clr_n;
        end
    end

    // Registered sensor and converter pins, decoded from the next state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sensor_clk <= 1'b0;
            sensor_si  <= 1'b0;
            adc_run    <= 1'b0;
        end else begin
            sensor_clk <= clk_high(state_n);
            sensor_si  <= (state_n == ST_SI_HI) && (tcnt_n < HI_LAST);
            adc_run    <= (state_n == ST_WAIT) ||
                          (((state_n == ST_PIX_HI) || (state_n == ST_PIX_LO)) &&
                           (pcnt_n != PIX_LAST));
        end
    end

    // Capture bookkeeping: busy window, done pulse, half select, overrun.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy         <= 1'b0;
            capture_done <= 1'b0;
            bank_q       <= 1'b0;
            overrun      <= 1'b0;
        end else begin
            if (start_cap)    busy <= 1'b1;
            else if (cap_end) busy <= 1'b0;
            capture_done <= cap_end;
            if (start_cap) bank_q <= ~bank_q;
            overrun <= adc_ready && ((state_q == ST_PIX_HI) || (state_q == ST_PIX_LO));
        end
    end

    // Hold the converter result taken with an accepted strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)                                sample_q <= '0;
        else if ((state_q == ST_WAIT) && adc_ready) sample_q <= adc_data;
    end

    lsr_pingpong_mem #(.NPIX(NPIX), .DW(DW)) u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (store_we),
        .wr_bank (bank_q),
        .wr_addr (AW'(pcnt_q)),
        .wr_data (sample_q),
        .rd_bank (~bank_q),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    lsr_capture_stats #(.CW(CW), .NW(NW)) u_stats (
        .clk      (clk),
        .rst_n    (rst_n),
        .busy_i   (busy),
        .done_i   (capture_done),
        .cycles_o (capture_cycles),
        .count_o  (capture_count)
    );

    // Length of the current high phase of the pixel clock, for the width check.
    logic [TW:0] hi_run_q;
    always_ff @(posedge clk) begin
        if (!rst_n)          hi_run_q <= '0;
        else if (!sensor_clk) hi_run_q <= '0;
        else if (hi_run_q != '1) hi_run_q <= hi_run_q + 1'b1;
    end

    a_r5_high_width: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sensor_clk) |-> hi_run_q == (TW+1)'(HIGH_CYC));
    a_r5_store_after_rise: assert property (@(posedge clk) disable iff (!rst_n)
        store_we |-> sensor_clk);
    a_r5_store_before_fall: assert property (@(posedge clk) disable iff (!rst_n)
        store_we |=> sensor_clk);
    a_r3_si_inside_clock: assert property (@(posedge clk) disable iff (!rst_n)
        sensor_si |-> sensor_clk);
    a_r3_si_falls_first: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sensor_si) |-> sensor_clk);
    a_r4_rise_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (adc_ready && state_q == ST_WAIT) |=> sensor_clk && !overrun);
    a_r7_no_pulse_on_overrun: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |-> !$rose(sensor_clk));
    a_r11_run_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
        adc_run |-> busy);
    a_r11_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        capture_done |-> !busy ##1 !capture_done);

endmodule

// File: tb/lsr_sequencer_tb.sv
// Bench: drives captures with a seeded random converter model plus directed
// cases (request during clearing, overrun strobe, merged requests) and checks
// pins, pulse counts, memory contents and statistics.
module lsr_sequencer_tb;

    localparam int N  = 16;
    localparam int DW = 8;
    localparam int H  = 3;
    localparam int L  = 2;
    localparam int CW = 32;
    localparam int NW = 16;
    localparam int AW = $clog2(N);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          capture_req = 1'b0;
    logic          adc_ready = 1'b0;
    logic [DW-1:0] adc_data = '0;
    logic          adc_run, sensor_si, sensor_clk, busy, capture_done, overrun;
    logic [AW-1:0] rd_addr = '0;
    logic [DW-1:0] rd_data;
    logic [CW-1:0] capture_cycles;
    logic [NW-1:0] capture_count;

    always #4 clk = ~clk;

    lsr_sequencer #(.NPIX(N), .DW(DW), .HIGH_CYC(H), .LOW_CYC(L),
                    .CLEAR_PASSES(2), .CW(CW), .NW(NW)) u_dut (
        .clk(clk), .rst_n(rst_n), .capture_req(capture_req),
        .adc_ready(adc_ready), .adc_data(adc_data), .adc_run(adc_run),
        .sensor_si(sensor_si), .sensor_clk(sensor_clk), .rd_addr(rd_addr),
        .rd_data(rd_data), .busy(busy), .capture_done(capture_done),
        .overrun(overrun), .capture_cycles(capture_cycles),
        .capture_count(capture_count)
    );

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;
    logic [DW-1:0] img [4][N];
    logic ovr_exp = 1'b0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int exp_init_pulses(int n);
        return 2 * (n + 2);
    endfunction

    function automatic int exp_capture_pulses(int n);
        return n + 3;
    endfunction

    // ---------------- monitor ----------------
    int rise_cnt = 0, si_cnt = 0, rise0 = 0, acc = 0, bcnt = 0, bcnt_last = 0;
    int hi_len = 0, lo_len = 0, done_total = 0, ovr_seen = 0;
    bit had_fall = 0, first_cap = 1;
    logic clk_p = 0, si_p = 0, busy_p = 0, run_p = 0, done_p = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (busy && !busy_p) begin
                if (first_cap) begin
                    chk(rise_cnt == exp_init_pulses(N), "R2 clear pulses", rise_cnt, exp_init_pulses(N));
                    chk(si_cnt == 2, "R2 clear start pulses", si_cnt, 2);
                    first_cap = 0;
                end
                rise0 = rise_cnt; acc = 0; bcnt = 0;
            end
            if (busy) bcnt++;
            if (sensor_clk && !clk_p) begin
                rise_cnt++;
                if (had_fall) chk(lo_len >= L, "R5 low width", lo_len, L);
                hi_len = 1;
            end else if (sensor_clk) hi_len++;
            if (!sensor_clk && clk_p) begin
                chk(hi_len == H, "R5 high width", hi_len, H);
                had_fall = 1; lo_len = 1;
            end else if (!sensor_clk) lo_len++;
            if (sensor_si && !si_p) begin
                chk(sensor_clk && !clk_p, "R3 start with clock rise", sensor_clk, 1);
                si_cnt++;
            end
            if (!sensor_si && si_p) chk(sensor_clk, "R3 start falls before clock", sensor_clk, 1);
            if (adc_run && !run_p)
                chk(rise_cnt - rise0 == 2 && !sensor_clk, "R3 converter after first pulse", rise_cnt - rise0, 2);
            if (adc_ready) begin
                if (ovr_exp) begin
                    chk(overrun, "R7 overrun flag", overrun, 1);
                    ovr_seen++;
                end else begin
                    chk(sensor_clk && !clk_p, "R4 clock rise after strobe", sensor_clk, 1);
                    acc++;
                    if (acc == N) chk(!adc_run && run_p, "R6 converter stop", adc_run, 0);
                end
            end
            if (overrun && !(adc_ready && ovr_exp)) chk(0, "R7 spurious overrun", 1, 0);
            if (adc_run && !busy) chk(0, "R11 converter while idle", 1, 0);
            if (done_p) begin
                chk(capture_cycles == bcnt_last, "R10 cycle count", capture_cycles, bcnt_last);
                chk(capture_count == done_total, "R10 capture count", capture_count, done_total);
                chk(!capture_done, "R11 done width", capture_done, 0);
            end
            if (capture_done) begin
                done_total++;
                chk(rise_cnt - rise0 == exp_capture_pulses(N), "R6 pulses per capture",
                    rise_cnt - rise0, exp_capture_pulses(N));
                chk(!busy, "R11 busy low at done", busy, 0);
                chk(acc == N, "R6 accepted strobes", acc, N);
                bcnt_last = bcnt;
            end
        end
        clk_p = sensor_clk; si_p = sensor_si; busy_p = busy;
        run_p = adc_run; done_p = capture_done;
    end

    // ---------------- stimulus tasks ----------------
    task automatic pulse_req();
        @(negedge clk); capture_req <= 1'b1;
        @(negedge clk); capture_req <= 1'b0;
    endtask

    task automatic wait_done();
        @(negedge clk);
        while (!capture_done) @(negedge clk);
    endtask

    task automatic wait_busy();
        @(negedge clk);
        while (!busy) @(negedge clk);
    endtask

    task automatic drive_pixels(input int k, input bit inject);
        @(negedge clk);
        while (!adc_run) @(negedge clk);
        for (int p = 0; p < N; p++) begin
            logic [DW-1:0] d;
            d = DW'($urandom_range(0, 255));
            img[k][p] = d;
            adc_ready <= 1'b1; adc_data <= d;
            @(negedge clk);
            if (inject && p == 3) begin
                adc_ready <= 1'b1; adc_data <= ~d; ovr_exp <= 1'b1;
                @(negedge clk);
            end
            adc_ready <= 1'b0; ovr_exp <= 1'b0;
            if (p != N - 1) repeat (H + L + $urandom_range(0, 5)) @(negedge clk);
        end
    endtask

    task automatic read_check(input int k);
        for (int i = 0; i < N; i++) begin
            @(negedge clk); rd_addr <= AW'(i);
            @(negedge clk);
            chk(rd_data == img[k][i], "R8 stable half", rd_data, img[k][i]);
        end
    endtask

    // ---------------- main sequence ----------------
    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        chk(!sensor_clk && !sensor_si && !adc_run, "R1 pins in reset", sensor_clk, 0);
        chk(!busy && !capture_done && !overrun, "R1 flags in reset", busy, 0);
        chk(capture_count == 0 && capture_cycles == 0, "R1 stats in reset", capture_count, 0);
        @(negedge clk); rst_n <= 1'b1;
        repeat (20) @(negedge clk);
        chk(!busy, "R9 no start during clearing", busy, 0);
        pulse_req();
        drive_pixels(0, 1'b0);
        wait_done();
        pulse_req();
        fork
            drive_pixels(1, 1'b1);
            begin
                wait_busy();
                read_check(0);
                pulse_req();
                repeat (4) @(negedge clk);
                pulse_req();
            end
        join
        wait_done();
        repeat (2) @(negedge clk);
        chk(busy, "R9 held request starts", busy, 1);
        fork
            drive_pixels(2, 1'b0);
            read_check(1);
        join
        wait_done();
        repeat (40) @(negedge clk);
        chk(!busy && done_total == 3, "R9 merged requests", done_total, 3);
        pulse_req();
        fork
            drive_pixels(3, 1'b0);
            begin wait_busy(); read_check(2); end
        join
        wait_done();
        repeat (3) @(negedge clk);
        chk(done_total == 4, "R10 total captures", done_total, 4);
        chk(ovr_seen == 1, "R7 overrun seen", ovr_seen, 1);
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            chk(0, "watchdog", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

endmodule